// File: doc/BRIEF.md
# Banked Edge Capture Interrupt Controller

This block monitors 48 asynchronous digital inputs, arranged as three banks of 16 channels, and records a chosen transition on each channel in a sticky capture flag. Every input is first brought into the clock domain through a two-stage synchroniser. A transition is detected by comparing the current synchronised sample with the previous one. Each channel can be set to respond to rising or falling transitions.

Software uses a small register bus with single-cycle write strobes and registered reads. Through it, software turns capture on or off per channel, sets the polarity, chooses which channels may interrupt, and reads back the settings and the flags. A flag is removed only by writing 0 to that channel's capture-enable bit. Each channel's interrupt condition is its flag ANDed with its interrupt-select bit, and the 48 conditions are ORed onto one `irq` line. With every select bit at 0, software can still find captured transitions by polling the flags.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset, every capture-enable, interrupt-select, polarity and flag bit is 0, `irq` is 0 and `rdata` is 0.
- R2: Each bank b (0 to 2) has its registers at byte address 0x40 + 16*b plus an offset. Capture enable is at +0x0, interrupt select at +0x2, polarity at +0x4 and flags at +0x6 (read-only). A read strobe shows the register's contents on `rdata` in the next cycle. Unmapped addresses, and cycles with no read strobe, give 0 in the next cycle.
- R3: Channel c maps to bank c/16, bit c%16. A transition on one channel sets exactly that flag bit and no other.
- R4: With polarity bit 1, a 0-to-1 input change sets the flag. A 1-to-0 change does not.
- R5: With polarity bit 0, a 1-to-0 input change sets the flag. A 0-to-1 change does not.
- R6: A transition on a channel whose capture-enable bit is 0 sets no flag. Enabling the channel later does not recall that transition.
- R7: Once set, a flag stays set through further transitions. Writing 1 again to its capture-enable bit does not clear it.
- R8: Writing 0 to a channel's capture-enable bit clears its flag and any interrupt it was causing.
- R9: `irq` is 1 exactly when some channel has both its flag and its interrupt-select bit set. Flags are still captured while the select bit is 0.
- R10: If the write that disables a channel happens in the same cycle that a transition would set its flag, the flag ends up at 0.
- R11: Writes to the flag registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| din | input | 48 | Asynchronous channel inputs; bit c is channel c |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Register byte address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle after `rd_en` |
| irq | output | 1 | Merged interrupt request |

## Verification
The bench sweeps all 48 channels with a single-bit toggle, once for each polarity, and reads all three flag registers each time. A fault in the bank or bit mapping, or in transition selection, therefore shows up as a wrong one-hot pattern. After each clear, the reverse transition is applied to confirm that the opposite polarity is ignored. Directed sequences then check capture while the channel is disabled, stickiness under repeated toggles and under re-enable, interrupt gating against the select bit, writes to the flag register, and a disable write timed to the exact cycle in which a transition would be latched.

// File: rtl/eic_pkg.sv
package eic_pkg;
    localparam int BANK_BASE   = 'h40;
    localparam int BANK_STRIDE = 'h10;
    localparam int OFF_CAP     = 'h0;
    localparam int OFF_SEL     = 'h2;
    localparam int OFF_POL     = 'h4;
    localparam int OFF_FLG     = 'h6;

    function automatic int reg_addr(input int bank, input int off);
        return BANK_BASE + bank * BANK_STRIDE + off;
    endfunction
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
    parameter int W      = 48,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] st_d, st_q;

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/eic_bank.sv
module eic_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] smp,
    input  logic         wr_cap,
    input  logic         wr_sel,
    input  logic         wr_pol,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] cap_en,
    output logic [W-1:0] int_sel,
    output logic [W-1:0] pol,
    output logic [W-1:0] flags,
    output logic         irq_any
);
    typedef struct packed {
        logic [W-1:0] cap;
        logic [W-1:0] sel;
        logic [W-1:0] pol;
        logic [W-1:0] prev;
        logic [W-1:0] flag;
    } bank_t;

    bank_t        st_d, st_q;
    logic [W-1:0] hit_d;
    logic [W-1:0] keep_d;

    always_comb begin
        st_d   = st_q;
        hit_d  = (st_q.pol & smp & ~st_q.prev) | (~st_q.pol & ~smp & st_q.prev);
        keep_d = wr_cap ? wdata : '1;
        if (wr_cap) st_d.cap = wdata;
        if (wr_sel) st_d.sel = wdata;
        if (wr_pol) st_d.pol = wdata;
        st_d.prev = smp;
        // a clearing write overrides a transition latched in the same cycle
        st_d.flag = (st_q.flag | (hit_d & st_q.cap)) & keep_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_en  = st_q.cap;
    assign int_sel = st_q.sel;
    assign pol     = st_q.pol;
    assign flags   = st_q.flag;
    assign irq_any = |(st_q.flag & st_q.sel);
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl #(
    parameter int NBANK  = 3,
    parameter int BANK_W = 16,
    parameter int ADDR_W = 8,
    parameter int SYNC_N = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NBANK*BANK_W-1:0] din,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [BANK_W-1:0]       wdata,
    output logic [BANK_W-1:0]       rdata,
    output logic                    irq
);
    import eic_pkg::*;

    localparam int NCH = NBANK * BANK_W;

    logic [NCH-1:0]               smp;
    logic [NBANK-1:0][BANK_W-1:0] cap_v, sel_v, pol_v, flg_v;
    logic [NBANK-1:0]             wr_cap, wr_sel, wr_pol, irq_b;
    logic [NCH-1:0]               flag_all, cap_all, sel_all;
    logic [BANK_W-1:0]            rdata_d, rdata_q;
    int                           a_int;

    assign a_int = int'(addr);

    eic_sync #(.W(NCH), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(din), .q(smp)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign wr_cap[b] = wr_en && (a_int == reg_addr(b, OFF_CAP));
        assign wr_sel[b] = wr_en && (a_int == reg_addr(b, OFF_SEL));
        assign wr_pol[b] = wr_en && (a_int == reg_addr(b, OFF_POL));

        eic_bank #(.W(BANK_W)) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .smp    (smp[b*BANK_W +: BANK_W]),
            .wr_cap (wr_cap[b]),
            .wr_sel (wr_sel[b]),
            .wr_pol (wr_pol[b]),
            .wdata  (wdata),
            .cap_en (cap_v[b]),
            .int_sel(sel_v[b]),
            .pol    (pol_v[b]),
            .flags  (flg_v[b]),
            .irq_any(irq_b[b])
        );

        assign flag_all[b*BANK_W +: BANK_W] = flg_v[b];
        assign cap_all[b*BANK_W +: BANK_W]  = cap_v[b];
        assign sel_all[b*BANK_W +: BANK_W]  = sel_v[b];
    end

    always_comb begin
        rdata_d = '0;
        if (rd_en) begin
            for (int b = 0; b < NBANK; b++) begin
                if (a_int == reg_addr(b, OFF_CAP)) rdata_d = cap_v[b];
                if (a_int == reg_addr(b, OFF_SEL)) rdata_d = sel_v[b];
                if (a_int == reg_addr(b, OFF_POL)) rdata_d = pol_v[b];
                if (a_int == reg_addr(b, OFF_FLG)) rdata_d = flg_v[b];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;
    assign irq   = |irq_b;
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
    parameter int NBANK  = 3,
    parameter int BANK_W = 16,
    parameter int ADDR_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    wr_en,
    input logic                    rd_en,
    input logic [ADDR_W-1:0]       addr,
    input logic [BANK_W-1:0]       wdata,
    input logic [BANK_W-1:0]       rdata,
    input logic                    irq,
    input logic [NBANK*BANK_W-1:0] flag_all,
    input logic [NBANK*BANK_W-1:0] cap_all,
    input logic [NBANK*BANK_W-1:0] sel_all
);
    import eic_pkg::*;

    logic [NBANK-1:0] cap_hit;
    for (genvar b = 0; b < NBANK; b++) begin : g_hit
        assign cap_hit[b] = wr_en && (int'(addr) == reg_addr(b, OFF_CAP));
    end

    // R6
    flag_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_all & ~cap_all) == '0);

    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_hit == '0) |=> ((flag_all & $past(flag_all)) == $past(flag_all)));

    for (genvar b = 0; b < NBANK; b++) begin : g_clr
        // R8
        flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            cap_hit[b] |=> ((flag_all[b*BANK_W +: BANK_W] & ~$past(wdata)) == '0));
    end

    // R9
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (((flag_all & ~$past(flag_all)) != '0) || ((sel_all & ~$past(sel_all)) != '0)));

    // R2
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rdata == '0));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.NBANK(NBANK), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq),
    .flag_all(flag_all), .cap_all(cap_all), .sel_all(sel_all)
);

// File: tb/edge_irq_ctrl_tb.sv
module edge_irq_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int OCAP = 0, OSEL = 2, OPOL = 4, OFLG = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [47:0] din = '0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    int          n_run = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    edge_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    function automatic int ra(input int b, input int off);
        return 'h40 + 16 * b + off;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1; addr = 8'(a); wdata = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        rd_en = 1; addr = 8'(a);
        @(negedge clk);
        rd_en = 0;
        d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 100000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v;
        settle(3);
        chk("R1 rdata", rdata, 16'h0);
        chk("R1 irq", {15'b0, irq}, 16'h0);
        rst_n = 1;
        settle(1);
        for (int b = 0; b < 3; b++) begin
            rd(ra(b, OCAP), v); chk("R1 cap", v, 16'h0);
            rd(ra(b, OSEL), v); chk("R1 sel", v, 16'h0);
            rd(ra(b, OPOL), v); chk("R1 pol", v, 16'h0);
            rd(ra(b, OFLG), v); chk("R1 flg", v, 16'h0);
        end

        // R2 readback with distinct patterns per bank and register
        for (int b = 0; b < 3; b++) begin
            wr(ra(b, OCAP), 16'hA5C3 ^ 16'(b * 'h1111));
            wr(ra(b, OSEL), 16'h3C5A ^ 16'(b * 'h0101));
            wr(ra(b, OPOL), 16'h0FF0 ^ 16'(b * 'h1010));
        end
        for (int b = 0; b < 3; b++) begin
            rd(ra(b, OCAP), v); chk("R2 cap", v, 16'hA5C3 ^ 16'(b * 'h1111));
            rd(ra(b, OSEL), v); chk("R2 sel", v, 16'h3C5A ^ 16'(b * 'h0101));
            rd(ra(b, OPOL), v); chk("R2 pol", v, 16'h0FF0 ^ 16'(b * 'h1010));
        end
        rd('h48, v); chk("R2 unmapped", v, 16'h0);
        rd('h30, v); chk("R2 unmapped", v, 16'h0);
        for (int b = 0; b < 3; b++) begin
            wr(ra(b, OCAP), 16'h0); wr(ra(b, OSEL), 16'h0);
        end

        // R3 R4 R5 R9: sweep every channel, both polarities, interrupts off
        for (int p = 0; p < 2; p++) begin
            din = (p == 1) ? 48'h0 : {48{1'b1}};
            for (int b = 0; b < 3; b++) wr(ra(b, OPOL), (p == 1) ? 16'hFFFF : 16'h0);
            settle(4);
            for (int b = 0; b < 3; b++) begin
                wr(ra(b, OCAP), 16'h0); wr(ra(b, OCAP), 16'hFFFF);
            end
            for (int ch = 0; ch < 48; ch++) begin
                din[ch] = (p == 1);
                settle(4);
                for (int b = 0; b < 3; b++) begin
                    rd(ra(b, OFLG), v);
                    chk(p == 1 ? "R3 R4 rise map" : "R3 R5 fall map", v,
                        (ch / 16 == b) ? 16'(1 << (ch % 16)) : 16'h0);
                end
                chk("R9 polled no irq", {15'b0, irq}, 16'h0);
                wr(ra(ch / 16, OCAP), ~16'(1 << (ch % 16)));
                wr(ra(ch / 16, OCAP), 16'hFFFF);
                din[ch] = (p == 0);
                settle(4);
                rd(ra(ch / 16, OFLG), v);
                chk(p == 1 ? "R4 falling ignored" : "R5 rising ignored", v, 16'h0);
            end
        end

        // back to rising, all low, all disabled
        din = '0;
        for (int b = 0; b < 3; b++) begin
            wr(ra(b, OPOL), 16'hFFFF); wr(ra(b, OCAP), 16'h0);
        end
        settle(4);

        // R6 disabled channel captures nothing
        din[20] = 1; settle(4);
        rd(ra(1, OFLG), v); chk("R6 disabled", v, 16'h0);
        wr(ra(1, OCAP), 16'h0010); settle(2);
        rd(ra(1, OFLG), v); chk("R6 late enable", v, 16'h0);
        din[20] = 0; settle(4);

        // R7 sticky flag
        din[20] = 1; settle(4);
        din[20] = 0; settle(4);
        din[20] = 1; settle(4);
        rd(ra(1, OFLG), v); chk("R7 sticky", v, 16'h0010);
        wr(ra(1, OCAP), 16'h0010);
        rd(ra(1, OFLG), v); chk("R7 re-enable keeps", v, 16'h0010);

        // R11 flag register read-only
        wr(ra(1, OFLG), 16'h0000);
        wr(ra(0, OFLG), 16'hFFFF);
        rd(ra(1, OFLG), v); chk("R11 write ignored", v, 16'h0010);
        rd(ra(0, OFLG), v); chk("R11 write ignored", v, 16'h0);

        // R9 interrupt gating
        chk("R9 sel off", {15'b0, irq}, 16'h0);
        wr(ra(1, OSEL), 16'h0020);
        chk("R9 other sel", {15'b0, irq}, 16'h0);
        wr(ra(1, OSEL), 16'h0010);
        chk("R9 irq on", {15'b0, irq}, 16'h1);
        wr(ra(1, OSEL), 16'h0000);
        chk("R9 sel cleared", {15'b0, irq}, 16'h0);
        wr(ra(1, OSEL), 16'h0010);
        chk("R9 irq again", {15'b0, irq}, 16'h1);

        // R8 clear by disable
        wr(ra(1, OCAP), 16'h0000);
        chk("R8 irq cleared", {15'b0, irq}, 16'h0);
        rd(ra(1, OFLG), v); chk("R8 flag cleared", v, 16'h0);
        din[20] = 0; settle(4);
        din[20] = 1; settle(4);
        rd(ra(1, OFLG), v); chk("R8 needs re-enable", v, 16'h0);
        wr(ra(1, OCAP), 16'h0010);
        din[20] = 0; settle(4);
        din[20] = 1; settle(4);
        rd(ra(1, OFLG), v); chk("R8 recaptured", v, 16'h0010);
        chk("R8 irq back", {15'b0, irq}, 16'h1);
        wr(ra(1, OCAP), 16'h0000);
        wr(ra(1, OSEL), 16'h0000);

        // R10 clear wins against a same-cycle capture
        din[40] = 0;
        wr(ra(2, OCAP), 16'h0100);
        settle(4);
        din[40] = 1;
        @(negedge clk);
        wr(ra(2, OCAP), 16'h0000);
        settle(3);
        rd(ra(2, OFLG), v); chk("R10 clear wins", v, 16'h0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule